// File: doc/BRIEF.md
# Sign-First Successive Approximation Controller

This block sequences a 13-bit signed successive-approximation conversion. It owns the trial register and the result latch. The analog comparator and the DAC sit outside it. A one-cycle start pulse begins a conversion.

The conversion runs in a fixed order:

- **Polarity cycle.** The DAC is held at zero and the comparator bit decides the polarity of the held sample.
- **Magnitude cycles.** The controller runs a binary search over twelve magnitude bits, from the most significant down. It presents one trial code per clock and reads back one comparator bit per clock. The polarity found in the first cycle is driven out as `dacNegative`, so that external logic can mirror the DAC for negative inputs.
- **Latch cycle.** One further clock copies the working register into the output latch. At the same time two completion flags change: `eoc` goes high and `intN` goes low.

A sequencer-level abort pulse drops a conversion in progress. It leaves the last latched result untouched.

Top module: `sar_sign_first`

## Requirements
- R1: After reset, `busy`, `signPhase`, `eoc`, `trialCode` and `resultCode` are all zero and `intN` is one.
- R2: A start pulse while idle gives, one clock later, `busy`=1, `signPhase`=1, `trialCode`=0, `eoc`=0 and `intN`=1.
- R3: The polarity is taken from the comparator during the `signPhase` cycle. The sign is 0 when the comparator reads 1 (input above ground) and 1 otherwise. It is driven on `dacNegative` and stored in `resultCode[12]`.
- R4: In the clock after the polarity cycle, `trialCode` holds the MSB alone (0x800).
- R5: In each magnitude cycle the bit under test stays 1 if the comparator reads 1 and is cleared if it reads 0. The next lower bit is then set to 1, so the second trial is 0xC00 or 0x400.
- R6: The conversion takes 13 decision clocks plus one latch clock. Fourteen clocks after the start pulse is sampled, `resultCode` = {sign, 12-bit magnitude}, `eoc`=1, `intN`=0 and `busy`=0. One clock earlier, `eoc` is still 0.
- R7: `eoc` and `intN` always have opposite levels.
- R8: An abort pulse during a conversion makes `busy` 0 on the next clock. It keeps `eoc` at 0 and leaves `resultCode` unchanged. Abort takes priority over start.
- R9: A start pulse during a conversion is ignored. The conversion continues and ends with the same result.
- R10: `resultCode` changes only on the clock where `eoc` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin a conversion |
| abortPulse | input | 1 | One-cycle request to drop a running conversion |
| cmpIn | input | 1 | Comparator: 1 when the sample exceeds the current reference |
| trialCode | output | 12 | Magnitude code driven to the DAC |
| dacNegative | output | 1 | Polarity of the running conversion |
| signPhase | output | 1 | High during the polarity cycle (DAC at zero) |
| busy | output | 1 | Conversion in progress |
| resultCode | output | 13 | Latched result: bit 12 sign, bits 11..0 magnitude |
| eoc | output | 1 | High after a completed conversion |
| intN | output | 1 | Low after a completed conversion |

## Verification
The assertions check the cycle-level rules on every clock:

- the opposite levels of the two completion flags;
- the clearing of both flags on a start;
- the MSB-only first trial;
- the effect of an abort;
- a start during a conversion being ignored;
- the result latch changing only as `eoc` rises.

Only the bench scenarios can show that the binary search converges to the right code. They drive a comparator model over positive, negative, zero, full-scale and over-range samples and alternating bit patterns. They also check the exact latency and the two possible second-trial values.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SIGN,
    ST_BITS,
    ST_LATCH
  } convState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic takeSign;
    logic stepBit;
    logic latchOut;
  } sarStrobe_t;
endpackage

// File: rtl/sar_control.sv
module sar_control
  import sar_pkg::*;
#(
  parameter int MAG_BITS = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       abortPulse,
  output sarStrobe_t strobe,
  output logic       signPhase,
  output logic       busy,
  output logic       eoc,
  output logic       intN
);
  localparam int CW = (MAG_BITS > 1) ? $clog2(MAG_BITS) : 1;

  convState_t     state;
  logic [CW-1:0]  bitCnt;
  logic           doAbort;

  assign busy      = (state != ST_IDLE);
  assign signPhase = (state == ST_SIGN);
  assign doAbort   = abortPulse && busy;

  always_comb begin
    strobe          = '0;
    strobe.clearAll = doAbort || (startPulse && !busy && !abortPulse);
    strobe.takeSign = (state == ST_SIGN)  && !doAbort;
    strobe.stepBit  = (state == ST_BITS)  && !doAbort;
    strobe.latchOut = (state == ST_LATCH) && !doAbort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      eoc    <= 1'b0;
      intN   <= 1'b1;
    end else if (doAbort) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse && !abortPulse) begin
          state <= ST_SIGN;
          eoc   <= 1'b0;
          intN  <= 1'b1;
        end
        ST_SIGN: begin
          state  <= ST_BITS;
          bitCnt <= CW'(MAG_BITS - 1);
        end
        ST_BITS: begin
          if (bitCnt == '0) state <= ST_LATCH;
          else bitCnt <= bitCnt - 1'b1;
        end
        ST_LATCH: begin
          state <= ST_IDLE;
          eoc   <= 1'b1;
          intN  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int MAG_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic                cmpIn,
  output logic [MAG_BITS-1:0] trialCode,
  output logic                dacNegative,
  output logic [MAG_BITS:0]   resultCode
);
  localparam logic [MAG_BITS-1:0] TOP_BIT = {1'b1, {(MAG_BITS-1){1'b0}}};

  logic [MAG_BITS-1:0] trialReg;
  logic [MAG_BITS-1:0] pointer;
  logic                signWork;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trialReg   <= '0;
      pointer    <= '0;
      signWork   <= 1'b0;
      resultCode <= '0;
    end else begin
      if (strobe.clearAll) begin
        trialReg <= '0;
        pointer  <= '0;
        signWork <= 1'b0;
      end else if (strobe.takeSign) begin
        signWork <= !cmpIn;
        trialReg <= TOP_BIT;
        pointer  <= TOP_BIT;
      end else if (strobe.stepBit) begin
        trialReg <= (cmpIn ? trialReg : (trialReg & ~pointer)) | (pointer >> 1);
        pointer  <= pointer >> 1;
      end
      if (strobe.latchOut) resultCode <= {signWork, trialReg};
    end
  end

  assign trialCode   = trialReg;
  assign dacNegative = signWork;
endmodule

// File: rtl/sar_sign_first.sv
module sar_sign_first
  import sar_pkg::*;
#(
  parameter int MAG_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic                abortPulse,
  input  logic                cmpIn,
  output logic [MAG_BITS-1:0] trialCode,
  output logic                dacNegative,
  output logic                signPhase,
  output logic                busy,
  output logic [MAG_BITS:0]   resultCode,
  output logic                eoc,
  output logic                intN
);
  sarStrobe_t strobe;

  sar_control #(.MAG_BITS(MAG_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortPulse(abortPulse),
    .strobe(strobe), .signPhase(signPhase), .busy(busy), .eoc(eoc), .intN(intN)
  );

  sar_datapath #(.MAG_BITS(MAG_BITS)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .trialCode(trialCode), .dacNegative(dacNegative), .resultCode(resultCode)
  );
endmodule

// File: rtl/sar_sign_first_checker.sv
module sar_sign_first_checker #(
  parameter int MAG_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                startPulse,
  input logic                abortPulse,
  input logic [MAG_BITS-1:0] trialCode,
  input logic                signPhase,
  input logic                busy,
  input logic [MAG_BITS:0]   resultCode,
  input logic                eoc,
  input logic                intN
);
  localparam logic [MAG_BITS-1:0] TOP_BIT = {1'b1, {(MAG_BITS-1){1'b0}}};

  AST_FLAGS_OPPOSITE: assert property (@(posedge clk) disable iff (!rstN)
    eoc != intN); // R7
  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && !abortPulse) |=> (busy && signPhase && !eoc && intN)); // R2
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (signPhase && !abortPulse) |=> (trialCode == TOP_BIT)); // R4
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse && busy) |=> (!busy && !eoc && $stable(resultCode))); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && busy && !signPhase && !abortPulse) |=> !signPhase); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(eoc) |-> $stable(resultCode)); // R10
endmodule

bind sar_sign_first sar_sign_first_checker #(.MAG_BITS(MAG_BITS)) chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortPulse(abortPulse),
  .trialCode(trialCode), .signPhase(signPhase), .busy(busy),
  .resultCode(resultCode), .eoc(eoc), .intN(intN)
);

// File: tb/sar_sign_first_test.sv
module sar_sign_first_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        abortPulse = 1'b0;
  logic        cmpIn;
  logic [11:0] trialCode;
  logic        dacNegative, signPhase, busy, eoc, intN;
  logic [12:0] resultCode;

  int checks = 0;
  int fails = 0;
  int sampleHalf = 1;  // analog sample in half-LSB units, odd
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  // comparator model: polarity against ground, then magnitude against DAC
  always_comb begin
    int absHalf;
    absHalf = (sampleHalf < 0) ? -sampleHalf : sampleHalf;
    if (signPhase) cmpIn = (sampleHalf > 0);
    else           cmpIn = (absHalf > 2 * int'(trialCode));
  end

  sar_sign_first uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortPulse(abortPulse),
    .cmpIn(cmpIn), .trialCode(trialCode), .dacNegative(dacNegative),
    .signPhase(signPhase), .busy(busy), .resultCode(resultCode),
    .eoc(eoc), .intN(intN)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // full conversion; midStart pulses start during the run
  task automatic runConversion(input int mag, input bit neg, input bit midStart);
    int expMag;
    int oldRes;
    expMag = (mag > 4095) ? 4095 : mag;
    sampleHalf = neg ? -(2 * mag + 1) : (2 * mag + 1);
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2 busy", busy, 1);
    check("R2 signPhase", signPhase, 1);
    check("R2 trial zero", trialCode, 0);
    check("R2 eoc low", eoc, 0);
    check("R2 intN high", intN, 1);
    oldRes = resultCode;
    @(negedge clk);
    check("R4 first trial", trialCode, 12'h800);
    check("R3 polarity", dacNegative, neg);
    @(negedge clk);
    check("R5 second trial", trialCode, (expMag >= 2048) ? 12'hC00 : 12'h400);
    if (midStart) begin
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      check("R9 still busy", busy, 1);
      check("R9 no restart", signPhase, 0);
      waitNeg(10);
    end else begin
      waitNeg(11);
    end
    check("R6 eoc not yet", eoc, 0);
    check("R10 result held", resultCode, oldRes);
    @(negedge clk);
    check("R6 eoc high", eoc, 1);
    check("R6 intN low", intN, 0);
    check("R7 opposite", eoc ^ intN, 1);
    check("R6 idle", busy, 0);
    check("R6 result", resultCode, {neg, 12'(expMag)});
    check("R3 sign bit", resultCode[12], neg);
  endtask

  task automatic testAbort();
    int oldRes;
    oldRes = resultCode;
    sampleHalf = 2 * 77 + 1;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    waitNeg(4);
    abortPulse = 1'b1;
    @(negedge clk);
    abortPulse = 1'b0;
    check("R8 busy cleared", busy, 0);
    check("R8 eoc low", eoc, 0);
    check("R8 result kept", resultCode, oldRes);
    waitNeg(16);
    check("R8 no late completion", eoc, 0);
    check("R8 result still kept", resultCode, oldRes);
  endtask

  initial begin
    waitNeg(3);
    check("R1 busy", busy, 0);
    check("R1 eoc", eoc, 0);
    check("R1 intN", intN, 1);
    check("R1 result", resultCode, 0);
    check("R1 trial", trialCode, 0);
    check("R1 signPhase", signPhase, 0);
    rstN = 1'b1;
    runConversion(1234, 1'b0, 1'b0);
    runConversion(1234, 1'b1, 1'b0);
    runConversion(0, 1'b0, 1'b0);
    runConversion(4095, 1'b0, 1'b0);
    runConversion(5000, 1'b1, 1'b0);
    runConversion(12'hAAA, 1'b0, 1'b0);
    runConversion(12'h555, 1'b1, 1'b1);
    testAbort();
    runConversion(2048, 1'b0, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule